// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block collects a bank of level-sensitive peripheral interrupt request lines and steers each one onto one of a small set of core interrupt outputs. Which output a source drives is set by a rewritable per-source route field. After reset the route fields hold a fixed default routing table. A per-source enable mask gates every source, and each core output is the registered OR of all enabled sources routed to it. Priority among the core outputs is resolved further downstream.

Software configures the block over a simple register bus with separate write and read strobes. The route fields are packed several to a word across a few route registers. One register holds the enable mask. Two read-only registers return the raw request lines and the masked request lines.

Top module: `irq_router`

## Requirements
- R1: After reset the route fields hold this table: sources 0–6 and 24–31 route to output 0, sources 7–8 to output 1, sources 9–12 to output 2, sources 13–15 to output 3, sources 16–18 to output 4, sources 19–20 to output 5, and sources 21–23 to output 6.
- R2: After reset the enable mask is all zeros and every core output is low, whatever the request lines do.
- R3: Core output k is high in the cycle after a clock edge at which some source is high, enabled and routed to k. It is low in the cycle after an edge at which no such source exists.
- R4: A source whose route field holds a value above 6 drives no core output.
- R5: Route register a (address a, 0 to 3) holds the 4-bit route field of source 8a+j at bits 4j+3:4j. Writing it updates those fields, and reading it returns them.
- R6: Address 4 holds the enable mask, with bit i enabling source i. It is read and written whole.
- R7: Address 5 returns the raw request lines, whatever the mask. Writes to addresses 5 and 6 change no state.
- R8: Address 6 returns the request lines ANDed with the enable mask.
- R9: Read data is valid in the cycle after the read strobe, and reads of addresses 7 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level-sensitive peripheral request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| core_irq | output | 7 | Registered core interrupt outputs |

## Verification
First, each default route is checked one source at a time with the mask fully open, so that a swapped table entry shows up on the wrong output. Random masks, random route fields (including values above 6) and random request patterns then run against a bench model. These runs separate a missing mask gate, a wrong field position and an out-of-range field that still routes somewhere. Directed cases cover all-ones requests with the mask closed, writes to the read-only status words, and reads of unused addresses.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned RT_FIELD_W = 4;

  // Reset routing table, computed per source index
  function automatic logic [RT_FIELD_W-1:0] rt_default(input int unsigned src);
    if (src <= 6)       return 4'd0;
    else if (src <= 8)  return 4'd1;
    else if (src <= 12) return 4'd2;
    else if (src <= 15) return 4'd3;
    else if (src <= 18) return 4'd4;
    else if (src <= 20) return 4'd5;
    else if (src <= 23) return 4'd6;
    else                return 4'd0;
  endfunction

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [N_SRC-1:0]                    irq_src,
  input  logic                                bus_wr,
  input  logic                                bus_rd,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [DATA_W-1:0]                   bus_wdata,
  output logic [DATA_W-1:0]                   bus_rdata,
  output logic [N_SRC-1:0][RT_FIELD_W-1:0]    route_q,
  output logic [N_SRC-1:0]                    enable_q
);

  localparam int FPR        = DATA_W / RT_FIELD_W;
  localparam int N_RT_REGS  = N_SRC / FPR;
  localparam int A_MASK     = N_RT_REGS;
  localparam int A_RAW      = N_RT_REGS + 1;
  localparam int A_MSKD     = N_RT_REGS + 2;

  logic [DATA_W-1:0] rd_mux;

  // Route fields, one generate slice per route register
  for (genvar r = 0; r < N_RT_REGS; r++) begin : g_rt
    for (genvar j = 0; j < FPR; j++) begin : g_fld
      always_ff @(posedge clk) begin
        if (rst)
          route_q[r*FPR+j] <= rt_default(r*FPR+j);
        else if (bus_wr && (int'(bus_addr) == r))
          route_q[r*FPR+j] <= bus_wdata[j*RT_FIELD_W +: RT_FIELD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      enable_q <= '0;
    else if (bus_wr && (int'(bus_addr) == A_MASK))
      enable_q <= bus_wdata[N_SRC-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) < N_RT_REGS) begin
      for (int j = 0; j < FPR; j++)
        rd_mux[j*RT_FIELD_W +: RT_FIELD_W] = route_q[int'(bus_addr)*FPR + j];
    end else if (int'(bus_addr) == A_MASK) begin
      rd_mux[N_SRC-1:0] = enable_q;
    end else if (int'(bus_addr) == A_RAW) begin
      rd_mux[N_SRC-1:0] = irq_src;
    end else if (int'(bus_addr) == A_MSKD) begin
      rd_mux[N_SRC-1:0] = irq_src & enable_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_mux;
  end

  assert_reset_default_R1: assert property (@(posedge clk)
    $fell(rst) |-> (route_q[0] == 4'd0 && route_q[8] == 4'd1 && route_q[12] == 4'd2 &&
                    route_q[15] == 4'd3 && route_q[16] == 4'd4 && route_q[20] == 4'd5 &&
                    route_q[23] == 4'd6 && route_q[N_SRC-1] == 4'd0));

  assert_mask_write_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr) == A_MASK) |=> (enable_q == $past(bus_wdata[N_SRC-1:0])));

  assert_raw_read_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) == A_RAW) |=> (bus_rdata[N_SRC-1:0] == $past(irq_src)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) > A_MSKD) |=> (bus_rdata == '0));

endmodule

// File: rtl/irq_router_fabric.sv
module irq_router_fabric
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int N_OUT = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [N_SRC-1:0]                 irq_src,
  input  logic [N_SRC-1:0]                 enable_q,
  input  logic [N_SRC-1:0][RT_FIELD_W-1:0] route_q,
  output logic [N_OUT-1:0]                 core_irq
);

  logic [N_SRC-1:0] live;
  logic [N_OUT-1:0] core_d;

  assign live = irq_src & enable_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_SRC-1:0] hit;
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign hit[i] = live[i] && (route_q[i] == RT_FIELD_W'(k));
    end
    assign core_d[k] = |hit;
  end

  always_ff @(posedge clk) begin
    if (rst) core_irq <= '0;
    else     core_irq <= core_d;
  end

  assert_closed_mask_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (enable_q == '0) |=> (core_irq == '0));

  assert_no_requests_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_src == '0) |=> (core_irq == '0));

endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_SRC  = 32,
  parameter int N_OUT  = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_OUT-1:0]  core_irq
);
  import irq_router_pkg::*;

  logic [N_SRC-1:0][RT_FIELD_W-1:0] route_q;
  logic [N_SRC-1:0]                 enable_q;

  irq_router_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .irq_src(irq_src),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .route_q(route_q), .enable_q(enable_q)
  );

  irq_router_fabric #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_fabric (
    .clk(clk), .rst(rst), .irq_src(irq_src),
    .enable_q(enable_q), .route_q(route_q), .core_irq(core_irq)
  );

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] irq_src;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [6:0]  core_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0]  m_route [32];
  logic [31:0] m_mask;

  irq_router u_dut (.*);

  always #5 clk = ~clk;

  function automatic logic [3:0] dflt(int s);
    if (s <= 6) return 0; if (s <= 8) return 1; if (s <= 12) return 2;
    if (s <= 15) return 3; if (s <= 18) return 4; if (s <= 20) return 5;
    if (s <= 23) return 6; return 0;
  endfunction

  function automatic logic [6:0] exp_core(logic [31:0] src);
    logic [6:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (src[i] && m_mask[i] && m_route[i] < 7) r[m_route[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w[j*4 +: 4] = m_route[a*8+j];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
    if (a < 4) for (int j = 0; j < 8; j++) m_route[a*8+j] = d[j*4 +: 4];
    else if (a == 4) m_mask = d;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic drive_src(logic [31:0] s, string req);
    @(negedge clk); irq_src = s;
    @(negedge clk);
    check(req, {25'd0, core_irq}, {25'd0, exp_core(s)});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst = 1; irq_src = '1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    for (int i = 0; i < 32; i++) m_route[i] = dflt(i);
    m_mask = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R2 reset core", {25'd0, core_irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      bus_read(a[3:0], rd); check("R1 default route word", rd, exp_word(a));
    end
    bus_read(4, rd); check("R2 mask reset", rd, 32'd0);
    drive_src('1, "R2 closed mask quiet");
    bus_read(5, rd); check("R7 raw status ignores mask", rd, 32'hFFFF_FFFF);
    // Each default route, one source at a time
    bus_write(4, '1);
    for (int s = 0; s < 32; s++) drive_src(32'd1 << s, "R1 default per source");
    // Out-of-range field
    bus_write(1, 32'h7777_F8F9);
    drive_src(32'h0000_FF00, "R4 field above 6 routes nowhere");
    bus_read(1, rd); check("R5 route readback", rd, 32'h7777_F8F9);
    // Status words are read-only
    irq_src = 32'h1234_5678;
    bus_write(5, 32'hDEAD_BEEF); bus_write(6, 32'hDEAD_BEEF);
    bus_read(4, rd); check("R7 status write ignored mask", rd, m_mask);
    bus_read(1, rd); check("R7 status write ignored route", rd, exp_word(1));
    bus_read(5, rd); check("R7 raw status", rd, 32'h1234_5678);
    for (int a = 7; a < 16; a++) begin
      bus_read(a[3:0], rd); check("R9 unmapped reads zero", rd, 32'd0);
    end
    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] s;
      if (n % 5 == 0) bus_write(4, $urandom);
      if (n % 3 == 0) begin
        logic [31:0] w = $urandom;
        bus_write(4'($urandom_range(0, 3)), w);
      end
      s = $urandom;
      drive_src(s, "R3 random routing");
      bus_read(6, rd); check("R8 masked status", rd, s & m_mask);
      if (n % 50 == 0) begin
        bus_read(4, rd); check("R6 mask readback", rd, m_mask);
        for (int a = 0; a < 4; a++) begin
          bus_read(a[3:0], rd); check("R5 route word", rd, exp_word(a));
        end
      end
    end
    drive_src(32'd0, "R3 no requests");
    done = 1;
    finish_run();
  end
endmodule